// File: doc/BRIEF.md
# BCD Calendar Clock Register Bank

This block keeps wall-clock time and the calendar date as packed BCD counters and shows them to a host through eight byte registers. The registers sit at the very top of a 19-bit byte address space. The rest of that space belongs to a memory array that lives outside this block, so any access below the top eight bytes is ignored here. The count is paced by enable pulses from a 32.768 kHz time base. A parameterised prescaler divides those pulses down to one advance per second. When the divide ratio is 1, the input is treated as an already prescaled 1 Hz enable.

The host never touches the live counters directly. It reads and writes a second copy of the registers, the user buffer. On every second the buffer is refreshed from the counters, unless the host has frozen it with a control bit or is holding it for a write. A hold bit lets the host compose a new time in the buffer while the counters keep running. When the hold bit is cleared, the composed values are loaded into the counters and the second starts again from zero.

The bus is a plain single-cycle byte bus with active-low chip, write and output enables. It has no stall and no back-pressure: a write is taken on the clock edge where it is presented, and read data is combinational from the buffer. A supply-fail input removes the block from the bus entirely.

Top module: `rtc_calendar_bank`

## Requirements
- R1: Only addresses 0x7FFF8 to 0x7FFFF respond, with the offset in addr[2:0]: 0 seconds, 1 minutes, 2 hours, 3 day-of-week, 4 date, 5 month, 6 year, 7 control/century. Reads and writes at every other address leave the registers unchanged and do not drive the bus.
- R2: Each register keeps only its valid BCD bits, and the unused high bits read as 0. Seconds and minutes keep bits [6:0], hours [5:0], day-of-week [2:0], date [5:0], month [4:0], year [7:0]. Offset 7 reads {hold, freeze, century[5:0]}. After reset the time is 00:00:00, day-of-week is 1, the date is 01/01, the year is 00, the century is 20 and both control bits are 0.
- R3: Seconds and minutes count 00 to 59 and then wrap, carrying into the next field. Hours count 00 to 23; the wrap to 00 advances the date.
- R4: The date wraps to 01 after the last day of its month: 31 for months 01, 03, 05, 07, 08, 10 and 12; 30 for months 04, 06, 09 and 11; 28 or 29 for month 02. The month then advances.
- R5: A year is a leap year, with February 29 valid, when the BCD year is divisible by 4. Year 00 is a leap year.
- R6: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00 and increments the century. Century 39 wraps to 00.
- R7: Day-of-week counts 1 to 7 and moves on by one at each date advance, wrapping from 7 to 1.
- R8: While the freeze bit (offset 7, bit 6) is 1, the user buffer is not refreshed from the counters, but the counters keep advancing. After the bit is cleared, the buffer next changes at the following one-second advance.
- R9: While the hold bit (offset 7, bit 7) is 1, host writes collect in the buffer and are not overwritten. A write to offset 7 with bit 7 = 0 while hold is 1 loads every buffered field into the counters one cycle later and restarts the prescaler. The next advance therefore comes a full DIV pulses after the load.
- R10: rdata_oe is 1, and rdata carries the addressed register, only when cs_n = 0, oe_n = 0, we_n = 1, the address decodes and pwr_fail = 0. Otherwise rdata is 0. A write happens on a clock edge with cs_n = 0 and we_n = 0 at a decoded address.
- R11: While pwr_fail is 1, chip enable is ignored: no data is driven and no write changes any register or control bit.
- R12: The counters advance once for every DIV osc_en pulses. With DIV = 1, each osc_en pulse is one second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_en | input | 1 | One-cycle pulse per time-base period |
| pwr_fail | input | 1 | Supply out of tolerance; deselects the bus |
| cs_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW (19) | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when not driven |
| rdata_oe | output | 1 | High when the block drives rdata |

## Verification
The hardest state to reach from the ports is a rollover deep in the chain, such as the last second of a century or February 28 in a year ending in 00. Counting there naturally would take years of simulated seconds. The stimulus gets there through the hold-and-load path: it writes a time one second short of the boundary, clears hold, and issues exactly DIV pulses. Randomly chosen dates that are biased toward month, day and hour ends then cover many short walks, each of one to three seconds. The freeze and hold windows are checked by giving time-base pulses while a bit is set and reading before and after the next advance.

// File: rtl/rtc_cal_pkg.sv
`timescale 1ns/1ps
package rtc_cal_pkg;

  typedef struct packed {
    logic [5:0] cen;
    logic [7:0] yr;
    logic [4:0] mon;
    logic [5:0] date;
    logic [2:0] dow;
    logic [5:0] hr;
    logic [6:0] min;
    logic [6:0] sec;
  } cal_t;

  typedef enum logic [2:0] {
    OFS_SEC  = 3'd0,
    OFS_MIN  = 3'd1,
    OFS_HR   = 3'd2,
    OFS_DOW  = 3'd3,
    OFS_DATE = 3'd4,
    OFS_MON  = 3'd5,
    OFS_YR   = 3'd6,
    OFS_CTRL = 3'd7
  } reg_ofs_e;

  localparam cal_t CAL_RESET = '{cen: 6'h20, yr: 8'h00, mon: 5'h01, date: 6'h01,
                                 dow: 3'd1, hr: 6'h00, min: 7'h00, sec: 7'h00};

  // Add one to a two-digit packed BCD value (no wrap handling).
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // Divisible by four in BCD: even tens need units 0/4/8, odd tens need 2/6.
  function automatic logic bcd_leap(input logic [7:0] yr);
    logic r;
    if (!yr[4]) r = (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    else        r = (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    return r;
  endfunction

  function automatic logic [5:0] month_end(input logic [4:0] mon, input logic leap);
    logic [5:0] r;
    case (mon)
      5'h02:                      r = leap ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: r = 6'h30;
      default:                    r = 6'h31;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rtc_sec_prescaler.sv
`timescale 1ns/1ps
module rtc_sec_prescaler #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_en,
  input  logic restart,
  output logic sec_tick
);

  generate
    if (DIV <= 1) begin : g_passthru
      assign sec_tick = osc_en & ~restart;
    end else begin : g_divide
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk) begin
        if (!rst_n || restart) cnt_q <= '0;
        else if (osc_en)       cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end

      assign sec_tick = osc_en & ~restart & (cnt_q == LAST);
    end
  endgenerate

endmodule

// File: rtl/rtc_count_chain.sv
`timescale 1ns/1ps
module rtc_count_chain
  import rtc_cal_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic load,
  input  cal_t load_val,
  output cal_t live,
  output cal_t live_nxt
);

  logic c_min, c_hr, c_day, c_mon, c_yr, c_cen;
  logic [7:0] t_sec, t_min, t_hr, t_date, t_mon, t_yr, t_cen;
  logic [5:0] last_day;

  assign t_sec    = bcd_inc({1'b0, live.sec});
  assign t_min    = bcd_inc({1'b0, live.min});
  assign t_hr     = bcd_inc({2'b0, live.hr});
  assign t_date   = bcd_inc({2'b0, live.date});
  assign t_mon    = bcd_inc({3'b0, live.mon});
  assign t_yr     = bcd_inc(live.yr);
  assign t_cen    = bcd_inc({2'b0, live.cen});
  assign last_day = month_end(live.mon, bcd_leap(live.yr));

  always_comb begin
    live_nxt = live;
    c_min = 1'b0; c_hr = 1'b0; c_day = 1'b0;
    c_mon = 1'b0; c_yr = 1'b0; c_cen = 1'b0;
    if (load) begin
      live_nxt = load_val;
    end else if (tick) begin
      if (live.sec >= 7'h59) begin live_nxt.sec = '0; c_min = 1'b1; end
      else                          live_nxt.sec = t_sec[6:0];
      if (c_min) begin
        if (live.min >= 7'h59) begin live_nxt.min = '0; c_hr = 1'b1; end
        else                          live_nxt.min = t_min[6:0];
      end
      if (c_hr) begin
        if (live.hr >= 6'h23) begin live_nxt.hr = '0; c_day = 1'b1; end
        else                         live_nxt.hr = t_hr[5:0];
      end
      if (c_day) begin
        live_nxt.dow = (live.dow >= 3'd7 || live.dow == 3'd0) ? 3'd1 : live.dow + 3'd1;
        if (live.date >= last_day) begin live_nxt.date = 6'h01; c_mon = 1'b1; end
        else                              live_nxt.date = t_date[5:0];
      end
      if (c_mon) begin
        if (live.mon >= 5'h12) begin live_nxt.mon = 5'h01; c_yr = 1'b1; end
        else                          live_nxt.mon = t_mon[4:0];
      end
      if (c_yr) begin
        if (live.yr >= 8'h99) begin live_nxt.yr = 8'h00; c_cen = 1'b1; end
        else                         live_nxt.yr = t_yr;
      end
      if (c_cen) begin
        live_nxt.cen = (live.cen >= 6'h39) ? 6'h00 : t_cen[5:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) live <= CAL_RESET;
    else        live <= live_nxt;
  end

endmodule

// File: rtl/rtc_user_bank.sv
`timescale 1ns/1ps
module rtc_user_bank
  import rtc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] ofs,
  input  logic [7:0] wdata,
  input  logic       copy_en,
  input  cal_t       copy_val,
  output cal_t       ubuf,
  output logic       hold_q,
  output logic       frz_q,
  output logic       load_req,
  output logic [7:0] rd_byte
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ubuf     <= CAL_RESET;
      hold_q   <= 1'b0;
      frz_q    <= 1'b0;
      load_req <= 1'b0;
    end else begin
      load_req <= wr_en && (ofs == OFS_CTRL) && !wdata[7] && hold_q;
      if (copy_en) ubuf <= copy_val;
      if (wr_en) begin
        case (ofs)
          OFS_SEC:  ubuf.sec  <= wdata[6:0];
          OFS_MIN:  ubuf.min  <= wdata[6:0];
          OFS_HR:   ubuf.hr   <= wdata[5:0];
          OFS_DOW:  ubuf.dow  <= wdata[2:0];
          OFS_DATE: ubuf.date <= wdata[5:0];
          OFS_MON:  ubuf.mon  <= wdata[4:0];
          OFS_YR:   ubuf.yr   <= wdata;
          default: begin
            ubuf.cen <= wdata[5:0];
            frz_q    <= wdata[6];
            hold_q   <= wdata[7];
          end
        endcase
      end
    end
  end

  always_comb begin
    case (ofs)
      OFS_SEC:  rd_byte = {1'b0, ubuf.sec};
      OFS_MIN:  rd_byte = {1'b0, ubuf.min};
      OFS_HR:   rd_byte = {2'b0, ubuf.hr};
      OFS_DOW:  rd_byte = {5'b0, ubuf.dow};
      OFS_DATE: rd_byte = {2'b0, ubuf.date};
      OFS_MON:  rd_byte = {3'b0, ubuf.mon};
      OFS_YR:   rd_byte = ubuf.yr;
      default:  rd_byte = {hold_q, frz_q, ubuf.cen};
    endcase
  end

endmodule

// File: rtl/rtc_calendar_bank.sv
`timescale 1ns/1ps
module rtc_calendar_bank
  import rtc_cal_pkg::*;
#(
  parameter int AW  = 19,
  parameter int DIV = 32768
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          osc_en,
  input  logic          pwr_fail,
  input  logic          cs_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          rdata_oe
);

  localparam int OFS_W = 3;

  logic       hit, sel, wr_en, rd_en;
  logic       sec_tick, copy_en, hold_q, frz_q, load_req;
  logic [7:0] rd_byte;
  cal_t       live_cal, live_nxt, ubuf;

  assign hit   = &addr[AW-1:OFS_W];
  assign sel   = ~cs_n & ~pwr_fail & hit;
  assign wr_en = sel & ~we_n;
  assign rd_en = sel & ~oe_n & we_n;

  assign copy_en  = sec_tick & ~hold_q & ~frz_q;
  assign rdata_oe = rd_en;
  assign rdata    = rd_en ? rd_byte : 8'h00;

  rtc_sec_prescaler #(.DIV(DIV)) u_presc (
    .clk      (clk),
    .rst_n    (rst_n),
    .osc_en   (osc_en),
    .restart  (load_req),
    .sec_tick (sec_tick)
  );

  rtc_count_chain u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (sec_tick),
    .load     (load_req),
    .load_val (ubuf),
    .live     (live_cal),
    .live_nxt (live_nxt)
  );

  rtc_user_bank u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .ofs      (addr[OFS_W-1:0]),
    .wdata    (wdata),
    .copy_en  (copy_en),
    .copy_val (live_nxt),
    .ubuf     (ubuf),
    .hold_q   (hold_q),
    .frz_q    (frz_q),
    .load_req (load_req),
    .rd_byte  (rd_byte)
  );

endmodule

// File: rtl/rtc_calendar_bank_chk.sv
`timescale 1ns/1ps
module rtc_calendar_bank_chk
  import rtc_cal_pkg::*;
#(
  parameter int AW = 19
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pwr_fail,
  input logic          cs_n,
  input logic          we_n,
  input logic          oe_n,
  input logic [AW-1:0] addr,
  input logic          rdata_oe,
  input cal_t          live,
  input cal_t          ubuf,
  input logic          hold_q,
  input logic          frz_q,
  input logic          wr_en
);

  // R10: bus drive only under the full read condition at a decoded address
  p_drive_rule_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> (!cs_n && !oe_n && we_n && (&addr[AW-1:3])));

  // R11: no drive while supply has failed
  p_no_drive_fail_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |-> !rdata_oe);

  // R11: no write lands while supply has failed (hold blocks copies)
  p_no_write_fail_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_fail && hold_q) |=> $stable(ubuf));

  // R8: a frozen buffer keeps its seconds unless the host writes
  p_frozen_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_q && !wr_en) |=> $stable(ubuf.sec));

  // R3: seconds and hours stay in range
  p_sec_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (live.sec <= 7'h59) && (live.sec[3:0] <= 4'd9));
  p_hr_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    live.hr <= 6'h23);

  // R4: date stays between 01 and 31
  p_date_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (live.date != 6'h00) && (live.date <= 6'h31));

  // R7: day-of-week never reaches zero
  p_dow_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    live.dow != 3'd0);

endmodule

bind rtc_calendar_bank rtc_calendar_bank_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pwr_fail (pwr_fail),
  .cs_n     (cs_n),
  .we_n     (we_n),
  .oe_n     (oe_n),
  .addr     (addr),
  .rdata_oe (rdata_oe),
  .live     (live_cal),
  .ubuf     (ubuf),
  .hold_q   (hold_q),
  .frz_q    (frz_q),
  .wr_en    (wr_en)
);

// File: tb/rtc_calendar_bank_tb.sv
`timescale 1ns/1ps
module rtc_calendar_bank_tb;

  localparam int AW  = 19;
  localparam int DIV = 4;
  localparam logic [18:0] BASE = 19'h7FFF8;
  localparam logic [18:0] CTRL = 19'h7FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_en = 1'b0, pwr_fail = 1'b0;
  logic cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic rdata_oe;

  int n_chk = 0, n_fail = 0;
  int m_s = 0, m_mi = 0, m_h = 0, m_dw = 1, m_dt = 1, m_mo = 1, m_y = 0, m_c = 20;

  always #2.5 clk = ~clk;

  rtc_calendar_bank #(.AW(AW), .DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .pwr_fail(pwr_fail),
    .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rdata_oe(rdata_oe)
  );

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int mdays(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_adv();
    m_s++;
    if (m_s == 60) begin
      m_s = 0; m_mi++;
      if (m_mi == 60) begin
        m_mi = 0; m_h++;
        if (m_h == 24) begin
          m_h = 0; m_dw = (m_dw == 7) ? 1 : m_dw + 1; m_dt++;
          if (m_dt > mdays(m_mo, m_y)) begin
            m_dt = 1; m_mo++;
            if (m_mo == 13) begin
              m_mo = 1; m_y++;
              if (m_y == 100) begin m_y = 0; m_c = (m_c == 39) ? 0 : m_c + 1; end
            end
          end
        end
      end
    end
  endtask

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [18:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; cs_n = 1'b0; we_n = 1'b0;
    @(negedge clk); cs_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic rd(input logic [18:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk); addr = a; cs_n = 1'b0; oe_n = 1'b0;
    #1; d = rdata; oe = rdata_oe;
    cs_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic osc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); osc_en = 1'b1;
      @(negedge clk); osc_en = 1'b0;
    end
  endtask

  task automatic set_time(input int c, input int y, input int mo, input int dt,
                          input int dw, input int h, input int mi, input int s);
    wr(CTRL, 8'h80 | to_bcd(c));
    wr(BASE + 0, to_bcd(s));
    wr(BASE + 1, to_bcd(mi));
    wr(BASE + 2, to_bcd(h));
    wr(BASE + 3, to_bcd(dw));
    wr(BASE + 4, to_bcd(dt));
    wr(BASE + 5, to_bcd(mo));
    wr(BASE + 6, to_bcd(y));
    wr(CTRL, to_bcd(c));
    @(negedge clk);
    m_c = c; m_y = y; m_mo = mo; m_dt = dt; m_dw = dw; m_h = h; m_mi = mi; m_s = s;
  endtask

  task automatic check_all(input string tag);
    logic [7:0] d; logic oe;
    rd(BASE + 0, d, oe); check({tag, " sec"},  d, to_bcd(m_s));
    rd(BASE + 1, d, oe); check({tag, " min"},  d, to_bcd(m_mi));
    rd(BASE + 2, d, oe); check({tag, " hr"},   d, to_bcd(m_h));
    rd(BASE + 3, d, oe); check({tag, " dow"},  d, to_bcd(m_dw));
    rd(BASE + 4, d, oe); check({tag, " date"}, d, to_bcd(m_dt));
    rd(BASE + 5, d, oe); check({tag, " mon"},  d, to_bcd(m_mo));
    rd(BASE + 6, d, oe); check({tag, " yr"},   d, to_bcd(m_y));
    rd(CTRL, d, oe);     check({tag, " cen"},  d, to_bcd(m_c));
  endtask

  task automatic step_check(input string tag);
    osc(DIV); model_adv(); check_all(tag);
  endtask

  bit done = 1'b0;

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d; logic oe; int r;
    void'($urandom(32'd20240229));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state, R10 idle bus
    check("R10 idle no drive", {7'b0, rdata_oe}, 8'h00);
    check_all("R2 reset");

    // R12 one advance per DIV pulses, R3 simple second
    osc(DIV - 1);
    rd(BASE, d, oe); check("R12 no advance before DIV", d, 8'h00);
    osc(1); model_adv();
    rd(BASE, d, oe); check("R12 advance at DIV", d, 8'h01);

    // Directed rollovers
    set_time(20, 24, 6, 15, 3, 12, 59, 59); step_check("R3 hour carry");
    set_time(20, 23, 2, 28, 2, 23, 59, 59); step_check("R4 feb28 nonleap");
    set_time(20, 24, 2, 28, 3, 23, 59, 59); step_check("R5 feb28 leap");
    set_time(20, 24, 2, 29, 4, 23, 59, 59); step_check("R5 feb29 end");
    set_time(20, 0, 2, 28, 1, 23, 59, 59);  step_check("R5 year00 leap");
    set_time(20, 99, 12, 31, 5, 23, 59, 59); step_check("R6 century carry");
    set_time(39, 99, 12, 31, 6, 23, 59, 59); step_check("R6 century wrap");
    set_time(21, 25, 4, 30, 7, 23, 59, 59); step_check("R7 dow wrap R4 april");
    set_time(21, 25, 11, 30, 2, 23, 59, 59); step_check("R4 november");

    // R9 prescaler restart on load
    wr(CTRL, 8'h80 | to_bcd(m_c));
    osc(3);
    set_time(21, 30, 7, 10, 4, 8, 30, 0);
    osc(DIV - 1);
    rd(BASE, d, oe); check("R9 restart no early advance", d, 8'h00);
    osc(1); model_adv();
    rd(BASE, d, oe); check("R9 restart advance", d, 8'h01);

    // R8 freeze: buffer stays, counters run
    wr(CTRL, 8'h40 | to_bcd(m_c));
    osc(2 * DIV); model_adv(); model_adv();
    rd(BASE, d, oe); check("R8 frozen sec", d, 8'h01);
    rd(CTRL, d, oe); check("R8 ctrl read", d, 8'h40 | to_bcd(m_c));
    wr(CTRL, to_bcd(m_c));
    rd(BASE, d, oe); check("R8 no refresh until next second", d, 8'h01);
    step_check("R8 resume");

    // R9 hold: writes collect, R2 field masks
    wr(CTRL, 8'h80 | to_bcd(m_c));
    wr(BASE + 3, 8'hFF);
    rd(BASE + 3, d, oe); check("R2 dow mask", d, 8'h07);
    wr(BASE + 0, 8'hC5);
    rd(BASE + 0, d, oe); check("R2 sec mask", d, 8'h45);
    osc(DIV);
    rd(BASE + 0, d, oe); check("R9 hold keeps written sec", d, 8'h45);

    // R1 decode: aliases and low addresses ignored
    wr(19'h7FFF0, 8'h12);
    wr(19'h3FFF8, 8'h13);
    rd(BASE + 0, d, oe); check("R1 alias write ignored", d, 8'h45);
    rd(19'h7FFF0, d, oe); check("R1 low read no drive", {7'b0, oe}, 8'h00);
    check("R1 low read data", d, 8'h00);

    // R11 supply fail
    pwr_fail = 1'b1;
    wr(BASE + 0, 8'h33);
    wr(CTRL, to_bcd(m_c));
    rd(BASE + 0, d, oe); check("R11 no drive", {7'b0, oe}, 8'h00);
    check("R11 data zero", d, 8'h00);
    pwr_fail = 1'b0;
    rd(BASE + 0, d, oe); check("R11 write blocked", d, 8'h45);
    rd(CTRL, d, oe); check("R11 hold unchanged", d, 8'h80 | to_bcd(m_c));

    // R10 no drive when write enable is low during a read
    @(negedge clk); addr = BASE; wdata = 8'h45; cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
    #1; check("R10 we low no drive", {7'b0, rdata_oe}, 8'h00);
    @(negedge clk); cs_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    wr(CTRL, to_bcd(m_c));
    @(negedge clk);

    // Random walks biased to boundaries
    for (int it = 0; it < 24; it++) begin
      int c, y, mo, dt, dw, h, mi, s, n;
      c  = $urandom % 40;
      y  = $urandom % 100;
      mo = 1 + $urandom % 12;
      dt = ($urandom % 2) ? mdays(mo, y) : 1 + $urandom % mdays(mo, y);
      dw = 1 + $urandom % 7;
      h  = ($urandom % 2) ? 23 : $urandom % 24;
      mi = ($urandom % 2) ? 59 : $urandom % 60;
      s  = 57 + $urandom % 3;
      n  = 1 + $urandom % 3;
      set_time(c, y, mo, dt, dw, h, mi, s);
      for (int k = 0; k < n; k++) begin osc(DIV); model_adv(); end
      check_all("R3 R4 R5 R6 R7 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule